// File: doc/BRIEF.md
# Window Watchdog with Disable and Supervisor Hold

This block supervises a processor by watching a kick signal. Once its window is open, each kick must land inside a band of clock counts: after a minimum spacing and before a maximum one. A kick that comes too early, or a window that runs out with no kick, starts a fault pulse of fixed length on an active-low, open-drain style output. The output is modelled by two signals, a drive-low enable and a released flag, which are always complementary.

An enable input switches the watchdog off at any moment. Taking it low releases the output at once, even halfway through a fault pulse. When the enable comes back, a fixed settling delay passes before window timing restarts. A separate input carries the block's own supervisor reset. While it is high the output stays released, and when it clears a fresh window starts. All durations are parameters in clock cycles. The kick input is synchronised by two flops and detected on its rising edge.

The controller has five states: `ST_OFF` (disabled), `ST_SETTLE` (restart delay), `ST_WINDOW` (kick timing), `ST_FAULT` (pulse driven) and `ST_HOLD` (supervisor reset held). The transitions are:
- Any state goes to OFF when the enable is low. Otherwise any state goes to HOLD when the supervisor reset is high.
- OFF goes to SETTLE.
- HOLD goes to WINDOW.
- SETTLE goes to WINDOW when its delay expires.
- WINDOW goes to FAULT on an early kick or on a timeout.
- WINDOW goes back to WINDOW, with its count cleared, on a kick inside the band.
- FAULT goes to WINDOW when the pulse ends.

Top module: `wdt_window_guard`

## Requirements
- R1: During and after power-on reset the output is released (drive 0, released flag 1) and the state is SETTLE. With no kicks, the first fault drive appears SETTLE_CYC+UP_CYC clock edges after reset is released.
- R2: When arm_i is low, fault_drive_o is 0 in the same cycle, even during a fault pulse. The pulse is abandoned, not finished.
- R3: Kick edges are ignored while arm_i is low and while the restart delay runs. They neither start a fault nor move the timing.
- R4: After arm_i returns high with no kicks, the fault drive appears SETTLE_CYC+UP_CYC+1 edges after the first edge that samples arm_i high.
- R5: If no kick is accepted within UP_CYC edges of a window start, fault_drive_o goes to 1.
- R6: A fault pulse holds fault_drive_o at 1 for exactly PULSE_CYC cycles. The output is then released and a new window starts.
- R7: A kick acted on while the window count is below LOW_CYC starts a fault pulse.
- R8: A kick acted on with the window count from LOW_CYC up to UP_CYC-1 restarts the window without a fault.
- R9: While sup_rst_i is high, the output is released in the same cycle. After it clears, a fresh window starts, and with no kicks the fault appears UP_CYC+1 edges after the first edge that samples it low.
- R10: A kick is taken from the rising edge of kick_i after a two-flop synchroniser, and is acted on at the third clock edge after the input rises. Kicks during a fault pulse are ignored, so the pulse length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| kick_i | input | 1 | Kick from the processor, asynchronous, rising edge counts |
| arm_i | input | 1 | Watchdog enable, low disables immediately |
| sup_rst_i | input | 1 | The block's own supervisor reset, active high |
| fault_drive_o | output | 1 | 1 = pull the fault line low |
| fault_rel_o | output | 1 | 1 = fault line released |

## Verification
A wrong state or count shows at the ports as a fault edge that moves by whole cycles. The edge arrives early or late against the settle, window and pulse budgets, so a counter off by one shows within one window length. A wrong disable or hold priority shows in the same cycle, as a driven output while arm_i is low or sup_rst_i is high. A lost or doubled kick shows within one window, as a spurious early fault or a missing restart. A cycle-level reference model is compared with both outputs on every cycle, under directed sequences and random kick, disable and hold traffic.

// File: rtl/wdt_win_pkg.sv
package wdt_win_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SETTLE = 3'd1,
        ST_WINDOW = 3'd2,
        ST_FAULT  = 3'd3,
        ST_HOLD   = 3'd4
    } wdt_state_e;

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], din};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wdt_span_counter.sv
module wdt_span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_window_guard.sv
module wdt_window_guard
    import wdt_win_pkg::*;
#(
    parameter int UP_CYC     = 7_875_000,
    parameter int LOW_CYC    = UP_CYC / 8,
    parameter int PULSE_CYC  = 25_000_000,
    parameter int SETTLE_CYC = 18_750,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic arm_i,
    input  logic sup_rst_i,
    output logic fault_drive_o,
    output logic fault_rel_o
);
    localparam int MAX_A = (UP_CYC > PULSE_CYC) ? UP_CYC : PULSE_CYC;
    localparam int MAX_C = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] UP_LAST     = CW'(UP_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST  = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] LOW_EDGE    = CW'(LOW_CYC);

    wdt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          kick_rise;
    logic          good_kick;
    logic          cnt_clr;

    wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (kick_i),
        .rise (kick_rise)
    );

    wdt_span_counter #(.W(CW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .cnt  (cnt_q)
    );

    // next-state decision: disable beats supervisor hold beats timing
    always_comb begin
        state_d   = state_q;
        good_kick = 1'b0;
        if (!arm_i) begin
            state_d = ST_OFF;
        end else if (sup_rst_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_SETTLE;
                ST_HOLD:   state_d = ST_WINDOW;
                ST_SETTLE: if (cnt_q == SETTLE_LAST) state_d = ST_WINDOW;
                ST_WINDOW: begin
                    if (kick_rise) begin
                        if (cnt_q < LOW_EDGE) state_d = ST_FAULT;
                        else                  good_kick = 1'b1;
                    end else if (cnt_q == UP_LAST) begin
                        state_d = ST_FAULT;
                    end
                end
                ST_FAULT:  if (cnt_q == PULSE_LAST) state_d = ST_WINDOW;
                default:   state_d = ST_SETTLE;
            endcase
        end
        cnt_clr = (state_d != state_q) || good_kick;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SETTLE;
        else        state_q <= state_d;
    end

    // outputs: released at once whenever disabled or held
    always_comb begin
        fault_drive_o = (state_q == ST_FAULT) && arm_i && !sup_rst_i;
        fault_rel_o   = !fault_drive_o;
    end
endmodule

// File: rtl/wdt_window_guard_chk.sv
module wdt_window_guard_chk
    import wdt_win_pkg::*;
#(
    parameter int UP_CYC     = 64,
    parameter int LOW_CYC    = 8,
    parameter int PULSE_CYC  = 64,
    parameter int SETTLE_CYC = 16,
    parameter int CW         = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic          sup_rst_i,
    input logic          kick_rise,
    input wdt_state_e    state_q,
    input logic [CW-1:0] cnt_q
);
    logic live;
    assign live = arm_i && !sup_rst_i;

    a_r2_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> state_q == ST_OFF);

    a_r3_settle_ignores_kick: assert property (@(posedge clk) disable iff (!rst_n)
        live && state_q == ST_SETTLE && cnt_q != CW'(SETTLE_CYC - 1) |=> state_q == ST_SETTLE);

    a_r4_rearm_settles: assert property (@(posedge clk) disable iff (!rst_n)
        live && state_q == ST_OFF |=> state_q == ST_SETTLE && cnt_q == '0);

    a_r5_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        live && state_q == ST_WINDOW && !kick_rise && cnt_q == CW'(UP_CYC - 1) |=> state_q == ST_FAULT);

    a_r6_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        live && state_q == ST_FAULT && cnt_q == CW'(PULSE_CYC - 1) |=> state_q == ST_WINDOW && cnt_q == '0);

    a_r7_early_kick: assert property (@(posedge clk) disable iff (!rst_n)
        live && state_q == ST_WINDOW && kick_rise && cnt_q < CW'(LOW_CYC) |=> state_q == ST_FAULT);

    a_r8_good_kick: assert property (@(posedge clk) disable iff (!rst_n)
        live && state_q == ST_WINDOW && kick_rise && cnt_q >= CW'(LOW_CYC) |=> state_q == ST_WINDOW && cnt_q == '0);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        live == 1'b0 && arm_i |=> state_q == ST_HOLD);
endmodule

bind wdt_window_guard wdt_window_guard_chk #(
    .UP_CYC    (UP_CYC),
    .LOW_CYC   (LOW_CYC),
    .PULSE_CYC (PULSE_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .CW        (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .sup_rst_i(sup_rst_i),
    .kick_rise(kick_rise),
    .state_q  (state_q),
    .cnt_q    (cnt_q)
);

// File: tb/sim_wdt_window_guard.sv
`timescale 1ns/1ps
module sim_wdt_window_guard;
    localparam int UP  = 40;
    localparam int LOW = 6;
    localparam int PUL = 25;
    localparam int SET = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick_i = 1'b0;
    logic arm_i = 1'b1;
    logic sup_rst_i = 1'b0;
    logic fault_drive_o, fault_rel_o;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_window_guard #(
        .UP_CYC(UP), .LOW_CYC(LOW), .PULSE_CYC(PUL), .SETTLE_CYC(SET)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .arm_i(arm_i),
        .sup_rst_i(sup_rst_i), .fault_drive_o(fault_drive_o), .fault_rel_o(fault_rel_o)
    );

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    // reference model, built from the requirements
    // modes: 0 off, 1 settle, 2 window, 3 fault, 4 hold
    int m_st, m_cnt, m_nst;
    bit k1, k2, k3, m_edge, m_rs;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 1; m_cnt = 0; k1 = 0; k2 = 0; k3 = 0;
        end else begin
            m_edge = k2 && !k3;
            m_nst = m_st;
            m_rs = 0;
            if (!arm_i) m_nst = 0;
            else if (sup_rst_i) m_nst = 4;
            else case (m_st)
                0: m_nst = 1;
                4: m_nst = 2;
                1: if (m_cnt == SET - 1) m_nst = 2;
                2: if (m_edge) begin
                       if (m_cnt < LOW) m_nst = 3; else m_rs = 1;
                   end else if (m_cnt == UP - 1) m_nst = 3;
                3: if (m_cnt == PUL - 1) m_nst = 2;
                default: m_nst = 1;
            endcase
            if (m_nst != m_st || m_rs) m_cnt = 0; else m_cnt++;
            m_st = m_nst;
            k3 = k2; k2 = k1; k1 = kick_i;
        end
    end

    function automatic int exp_drive(int st, bit arm, bit sup);
        return (st == 3 && arm && !sup) ? 1 : 0;
    endfunction

    // compare every cycle away from the edges
    always @(negedge clk) begin
        #1;
        if (!done) begin
            chk({tag, " drive"}, int'(fault_drive_o), exp_drive(m_st, arm_i, sup_rst_i));
            chk({tag, " released"}, int'(fault_rel_o), 1 - exp_drive(m_st, arm_i, sup_rst_i));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick_pulse();
        @(negedge clk); kick_i = 1'b1;
        step(2); kick_i = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        int u;
        int arm_left, sup_left, kick_left;
        u = $urandom(32'd1234);
        // R1: reset state
        step(3); #2;
        chk("R1 reset drive", int'(fault_drive_o), 0);
        chk("R1 reset rel", int'(fault_rel_o), 1);
        @(negedge clk); rst_n = 1'b1;
        step(SET + UP - 1); #2;
        chk("R1 no early fault", int'(fault_drive_o), 0);
        tag = "R5";
        step(1); #2;
        chk("R5 timeout fault", int'(fault_drive_o), 1);
        tag = "R6";
        step(PUL - 1); #2;
        chk("R6 pulse held", int'(fault_drive_o), 1);
        step(1); #2;
        chk("R6 pulse ended", int'(fault_drive_o), 0);

        // R2: disable mid pulse
        tag = "R2";
        step(UP); #2;
        chk("R2 fault running", int'(fault_drive_o), 1);
        step(5); arm_i = 1'b0; #2;
        chk("R2 released at once", int'(fault_drive_o), 0);
        tag = "R3";
        for (int i = 0; i < 15; i++) begin
            step(1); kick_i = ~kick_i;
        end
        step(1); kick_i = 1'b0;
        step(4); #2;
        chk("R3 disabled kicks ignored", int'(fault_drive_o), 0);
        @(negedge clk); arm_i = 1'b1;
        tag = "R4";
        step(SET + UP); #2;
        chk("R4 no fault before settle+window", int'(fault_drive_o), 0);
        step(1); #2;
        chk("R4 fault after re-arm", int'(fault_drive_o), 1);

        // R9: supervisor reset mid pulse
        tag = "R9";
        step(3); sup_rst_i = 1'b1; #2;
        chk("R9 released while held", int'(fault_drive_o), 0);
        step(10); sup_rst_i = 1'b0;
        step(UP); #2;
        chk("R9 fresh window no fault", int'(fault_drive_o), 0);
        step(1); #2;
        chk("R9 fault after fresh window", int'(fault_drive_o), 1);
        step(PUL - 1);

        // R8: kicks inside the band keep output released
        tag = "R8";
        step(10);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            kick_pulse();
            for (int j = 0; j < 18; j++) begin
                @(negedge clk); #2;
                if (fault_drive_o) seen++;
            end
        end
        chk("R8 no fault with good kicks", seen, 0);

        // R7: early kick
        tag = "R7";
        @(negedge clk); kick_i = 1'b1;
        step(2); kick_i = 1'b0;
        step(4); kick_i = 1'b1;
        step(2); #2;
        chk("R7 not yet acted on", int'(fault_drive_o), 0);
        step(1); #2;
        chk("R7 early kick fault", int'(fault_drive_o), 1);
        kick_i = 1'b0;

        // R10: kicks inside the pulse do not change its length
        tag = "R10";
        for (int i = 0; i < 4; i++) begin
            step(2); kick_i = 1'b1;
            step(2); kick_i = 1'b0;
        end
        step(PUL - 1 - 16); #2;
        chk("R10 pulse still held", int'(fault_drive_o), 1);
        step(1); #2;
        chk("R10 pulse length kept", int'(fault_drive_o), 0);

        // random traffic checked by the model every cycle
        tag = "R8 random";
        arm_left = 0; sup_left = 0; kick_left = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (arm_left > 0) begin
                arm_left--; if (arm_left == 0) arm_i = 1'b1;
            end else if ($urandom_range(0, 399) == 0) begin
                arm_i = 1'b0; arm_left = $urandom_range(1, 40);
            end
            if (sup_left > 0) begin
                sup_left--; if (sup_left == 0) sup_rst_i = 1'b0;
            end else if ($urandom_range(0, 499) == 0) begin
                sup_rst_i = 1'b1; sup_left = $urandom_range(1, 12);
            end
            if (kick_left > 0) begin
                kick_left--; if (kick_left == 0) kick_i = 1'b0;
            end else if ($urandom_range(0, 24) == 0) begin
                kick_i = 1'b1; kick_left = $urandom_range(1, 4);
            end
        end
        step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule